// File: doc/BRIEF.md
# Cascadable Input Capture Pair

This block holds two 16-bit input capture channels. Each one has its own counter and captures that counter's value when its pin shows the chosen transition. A counter does not count the system clock directly. It advances on a tick enable taken from a bus of source-timer ticks, so it moves in step with whichever timer feeds it. This holds even when that timer counts an external clock, because the external clock reaches the block only as a tick pulse. The counter can also be zeroed by a pulse on a chosen line of a sync bus, so several capture units share one time base.

Setting the cascade bit in channel 0's configuration joins the pair into one 32-bit unit. Channel 0 holds the low half and channel 1 holds the high half. The low half carries into the high half on the same clock as it wraps. A sync pulse zeroes both halves together, and a capture on channel 0's pin latches all 32 bits on one edge. A second setting, triggered mode, holds a counter at zero until its first selected trigger arrives.

Top module: `icap_pair`

## Requirements
- R1: After reset, all four readable registers read 0, both counters are 0 and `cap_irq` is low.
- R2: A counter advances by one on each clock on which the `src_tick` line chosen by its tick select (config bits [13:9]) is high, holds otherwise, and wraps from 0xFFFF to 0.
- R3: Config bits [1:0] choose the capture condition: 0 none, 1 rising, 2 falling, 3 every change. Each qualifying change loads the capture register and gives a one-cycle pulse on that channel's `cap_irq` bit. Other changes leave both unchanged.
- R4: Suppose a pin change is first sampled by clock edge E0. Then `cap_irq` rises after edge E2 and falls after E3. The value captured is the counter value that stands after E1.
- R5: With trigger mode (bit 2) at 0 and sync select (bits [8:4]) nonzero, a high on `sync_trig[sync select]` zeroes the counter on the next edge. This takes priority over a tick that arrives on the same clock. Sync select 0 means free running, and lines that are not selected have no effect.
- R6: Writing a config with trigger mode 1 and a nonzero sync select holds that counter at 0 until the first pulse on the selected sync line. The counter then counts freely, and later pulses on that line do not clear it.
- R7: When channel 0's bit 3 is set, the two counters form one 32-bit counter governed by channel 0's tick and sync selects. The high half increments on the clock where the low half wraps. Channel 1's selects and its pin have no effect.
- R8: In cascaded synchronous operation, a selected sync pulse zeroes both halves on the same edge.
- R9: In cascade mode, an event on channel 0's pin loads both capture registers on one edge from the 32-bit count and pulses `cap_irq[0]`, while `cap_irq[1]` stays low.
- R10: Without cascade, each channel counts, clears and captures only from its own config and its own pin.
- R11: Register addresses: 0 and 1 hold the configs of channel 0 and channel 1 and read back as written, bits [15:14] included. Address 2 is capture 0 (low half) and address 3 is capture 1 (high half). Both are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| cap_pin | input | 2 | Asynchronous capture pins, bit 0 for channel 0 |
| sync_trig | input | 32 | Sync trigger pulses from source timers, indexed by sync select |
| src_tick | input | 32 | Source-timer tick enables, indexed by tick select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational read data |
| cap_irq | output | 2 | One-cycle capture pulses per channel |

## Verification
Config writes, sync pulses and ticks take effect on the next clock edge. A capture result appears three edges after a pin change, as R4 sets out. The bench drives every input on the falling clock edge and stops all ticks before it moves a pin, so the expected capture value is simply the count of tick cycles since the last clear. It waits five cycles before reading, so the two synchronizer stages and the capture register have all settled. One directed case samples `cap_irq` in each of the cycles around E2 to pin down that latency exactly.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = 5;
  localparam int NSRC    = 1 << SEL_W;
  localparam int NCH     = 2;
  localparam int ADDR_W  = 2;
  localparam int SPARE_W = CNT_W - 4 - 2 * SEL_W;

  localparam logic [ADDR_W-1:0] A_CFG0 = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG1 = 2'd1;
  localparam logic [ADDR_W-1:0] A_CAP0 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAP1 = 2'd3;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic [SEL_W-1:0]   tick_sel;
    logic [SEL_W-1:0]   sync_sel;
    logic               cascade;
    logic               trig_mode;
    edge_mode_e         edge_mode;
  } icap_cfg_t;

  // Selected line of a trigger bus; select 0 never hits.
  function automatic logic sel_hit(input logic [SEL_W-1:0] sel,
                                   input logic [NSRC-1:0]  bus);
    return (sel != '0) && bus[sel];
  endfunction
endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det
  import icap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  edge_mode_e mode_i,
  output logic       edge_o
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            lvl;
  logic            prev;
  logic            rise;
  logic            fall;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    case (mode_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_ANY:  edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_cnt.sv
module icap_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  // clear and hold-at-zero win over the tick enable
  always_comb begin
    if (clr_i || hold_i) cnt_d = '0;
    else if (inc_i)      cnt_d = cnt_q + W'(1);
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/icap_pair.sv
module icap_pair
  import icap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cap_pin,
  input  logic [NSRC-1:0]   sync_trig,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NCH-1:0]    cap_irq
);
  icap_cfg_t        cfg_q     [NCH];
  icap_cfg_t        cfg_d     [NCH];
  icap_cfg_t        cfg_eff   [NCH];
  icap_cfg_t        wr_cfg;
  logic [CNT_W-1:0] cnt_w     [NCH];
  logic [CNT_W-1:0] cap_q     [NCH];
  logic [CNT_W-1:0] cap_d     [NCH];
  logic [NCH-1:0]   armed_q;
  logic [NCH-1:0]   armed_d;
  logic [NCH-1:0]   armed_eff;
  logic [NCH-1:0]   hit_own;
  logic [NCH-1:0]   hit_eff;
  logic [NCH-1:0]   clr;
  logic [NCH-1:0]   tick;
  logic [NCH-1:0]   inc;
  logic [NCH-1:0]   edge_w;
  logic [NCH-1:0]   load;
  logic [NCH-1:0]   irq_d;
  logic [NCH-1:0]   irq_q;
  logic             casc;
  logic             lo_wrap;

  assign casc    = cfg_q[0].cascade;
  assign wr_cfg  = icap_cfg_t'(wr_data);
  assign lo_wrap = &cnt_w[0];

  // effective control per half: channel 0 governs both halves in cascade
  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      cfg_eff[k]   = (k != 0 && casc) ? cfg_q[0] : cfg_q[k];
      armed_eff[k] = casc ? armed_q[0] : armed_q[k];
      hit_own[k]   = sel_hit(cfg_q[k].sync_sel, sync_trig);
      hit_eff[k]   = sel_hit(cfg_eff[k].sync_sel, sync_trig);
      clr[k]       = hit_eff[k] && (!cfg_eff[k].trig_mode || armed_eff[k]);
      tick[k]      = src_tick[cfg_eff[k].tick_sel];
    end
  end

  // the high half only steps on the low half's wrap when cascaded
  assign inc[0]   = tick[0];
  assign inc[1]   = tick[1] & (~casc | lo_wrap);
  assign load[0]  = edge_w[0];
  assign load[1]  = casc ? edge_w[0] : edge_w[1];
  assign irq_d[0] = edge_w[0];
  assign irq_d[1] = edge_w[1] & ~casc;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    icap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pin[g]),
      .mode_i (cfg_q[g].edge_mode),
      .edge_o (edge_w[g])
    );

    icap_cnt #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr[g]),
      .hold_i (armed_eff[g]),
      .inc_i  (inc[g]),
      .cnt_o  (cnt_w[g])
    );
  end

  // next state: config, trigger arming, capture registers
  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      cfg_d[k]   = cfg_q[k];
      armed_d[k] = armed_q[k];
      cap_d[k]   = cap_q[k];
      if (hit_own[k]) armed_d[k] = 1'b0;
      if (wr_en && (wr_addr == ADDR_W'(k))) begin
        cfg_d[k]   = wr_cfg;
        armed_d[k] = wr_cfg.trig_mode && (wr_cfg.sync_sel != '0);
      end
      if (load[k]) cap_d[k] = cnt_w[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        cfg_q[k] <= '0;
        cap_q[k] <= '0;
      end
      armed_q <= '0;
      irq_q   <= '0;
    end else begin
      for (int k = 0; k < NCH; k++) begin
        cfg_q[k] <= cfg_d[k];
        cap_q[k] <= cap_d[k];
      end
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG0:  rd_data = cfg_q[0];
      A_CFG1:  rd_data = cfg_q[1];
      A_CAP0:  rd_data = cap_q[0];
      A_CAP1:  rd_data = cap_q[1];
      default: rd_data = '0;
    endcase
  end

  assign cap_irq = irq_q;
endmodule

// File: rtl/icap_pair_chk.sv
module icap_pair_chk
  import icap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  sync_trig,
  input logic [NSRC-1:0]  src_tick,
  input logic             casc0,
  input logic             trig0,
  input logic [SEL_W-1:0] ssel0,
  input logic [SEL_W-1:0] tsel0,
  input logic             trig1,
  input logic [SEL_W-1:0] ssel1,
  input logic             armed0,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi,
  input logic [CNT_W-1:0] cap_lo,
  input logic [NCH-1:0]   irq
);
  logic             hit0;
  logic             hit1;
  logic             tk0;
  logic [CNT_W-1:0] hi_plus;

  always_comb begin
    hit0    = sel_hit(ssel0, sync_trig);
    hit1    = sel_hit(ssel1, sync_trig);
    tk0     = src_tick[tsel0];
    hi_plus = cnt_hi + CNT_W'(1);
  end

  AST_CASC_SYNC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (casc0 && !trig0 && hit0) |=> (cnt_lo == '0 && cnt_hi == '0)); // R8

  AST_CASC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (casc0 && !hit0 && !armed0 && tk0 && cnt_lo == '1)
      |=> (cnt_lo == '0 && cnt_hi == $past(hi_plus))); // R7

  AST_CASC_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (casc0 && !hit0 && !armed0 && cnt_lo != '1) |=> $stable(cnt_hi)); // R7

  AST_SINGLE_SYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc0 && !trig1 && hit1) |=> (cnt_hi == '0)); // R5

  AST_CASC_IRQ1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (casc0 && $past(casc0)) |-> !irq[1]); // R9

  AST_CAP_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq[0] |-> $stable(cap_lo)); // R3
endmodule

bind icap_pair icap_pair_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_trig (sync_trig),
  .src_tick  (src_tick),
  .casc0     (cfg_q[0].cascade),
  .trig0     (cfg_q[0].trig_mode),
  .ssel0     (cfg_q[0].sync_sel),
  .tsel0     (cfg_q[0].tick_sel),
  .trig1     (cfg_q[1].trig_mode),
  .ssel1     (cfg_q[1].sync_sel),
  .armed0    (armed_q[0]),
  .cnt_lo    (cnt_w[0]),
  .cnt_hi    (cnt_w[1]),
  .cap_lo    (cap_q[0]),
  .irq       (cap_irq)
);

// File: tb/test_icap_pair.sv
`timescale 1ns/1ps
module test_icap_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pin;
  logic [31:0] sync;
  logic [31:0] tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  cap_irq;

  int tests = 0;
  int fails = 0;
  int irq0_n = 0;
  int irq1_n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  icap_pair i_icap_pair (
    .clk(clk), .rst_n(rst_n), .cap_pin(pin), .sync_trig(sync),
    .src_tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_irq(cap_irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_irq[0]) irq0_n++;
      if (cap_irq[1]) irq1_n++;
    end
  end

  // {mode[1:0], from, to, ticks[15:0], expect_irq}; channel 0, sync line 3, tick line 1
  localparam logic [20:0] VECS [0:7] = '{
    {2'd1, 1'b0, 1'b1, 16'd5,   1'b1},
    {2'd1, 1'b1, 1'b0, 16'd6,   1'b0},
    {2'd2, 1'b1, 1'b0, 16'd9,   1'b1},
    {2'd2, 1'b0, 1'b1, 16'd2,   1'b0},
    {2'd3, 1'b0, 1'b1, 16'd12,  1'b1},
    {2'd3, 1'b1, 1'b0, 16'd0,   1'b1},
    {2'd0, 1'b0, 1'b1, 16'd3,   1'b0},
    {2'd1, 1'b0, 1'b1, 16'd300, 1'b1}
  };

  function automatic logic [15:0] mk(input logic [1:0] m, input logic tr,
                                     input logic cs, input logic [4:0] ss,
                                     input logic [4:0] ts);
    return {2'b00, ts, ss, cs, tr, m};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic sync_pulse(input logic [31:0] m);
    @(negedge clk); sync = m;
    @(negedge clk); sync = '0;
  endtask

  task automatic run_ticks(input int line, input int n);
    if (n > 0) begin
      @(negedge clk); tick[line] = 1'b1;
      repeat (n) @(negedge clk);
      tick = '0;
    end
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); pin[ch] = v;
    repeat (5) @(negedge clk);
  endtask

  // rising event on one pin with counts of pulses seen during it
  task automatic capture(input int ch);
    set_pin(ch, 1'b0);
    @(negedge clk); irq0_n = 0; irq1_n = 0; pin[ch] = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d, d2;
    logic [15:0] track;
    rst_n = 1'b0; pin = '0; sync = '0; tick = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg after reset", {16'd0, d}, 32'd0);
    end
    chk("R1 irq after reset", {30'd0, cap_irq}, 32'd0);

    // R3 / R2: table of edge modes with tick counts
    track = '0;
    for (int v = 0; v < 8; v++) begin
      logic [20:0] e;
      e = VECS[v];
      wr(2'd0, mk(2'd0, 1'b0, 1'b0, 5'd3, 5'd1));
      set_pin(0, e[18]);
      wr(2'd0, mk(e[20:19], 1'b0, 1'b0, 5'd3, 5'd1));
      sync_pulse(32'd1 << 3);
      run_ticks(1, int'(e[16:1]));
      @(negedge clk); irq0_n = 0; irq1_n = 0; pin[0] = e[17];
      repeat (5) @(negedge clk);
      if (e[0]) track = e[16:1];
      chk("R3 irq0 pulses", irq0_n, {31'd0, e[0]});
      chk("R10 irq1 quiet", irq1_n, 32'd0);
      rd(2'd2, d);
      chk("R2 captured tick count", {16'd0, d}, {16'd0, track});
    end

    // R11: config readback, capture registers read-only
    wr(2'd0, 16'hC000 | mk(2'd1, 1'b0, 1'b0, 5'd3, 5'd1));
    rd(2'd0, d);
    chk("R11 cfg readback", {16'd0, d}, {16'd0, 16'hC000 | mk(2'd1, 1'b0, 1'b0, 5'd3, 5'd1)});
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d);
    chk("R11 capture write ignored", {16'd0, d}, 32'd300);

    // R4: latency of the capture pulse
    set_pin(0, 1'b0);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R4 no pulse after E1", {31'd0, cap_irq[0]}, 32'd0);
    @(negedge clk); chk("R4 pulse after E2", {31'd0, cap_irq[0]}, 32'd1);
    @(negedge clk); chk("R4 pulse ends after E3", {31'd0, cap_irq[0]}, 32'd0);

    // R5: sync priority, unselected line, select 0
    sync_pulse(32'd1 << 3);
    run_ticks(1, 4);
    @(negedge clk); sync = 32'd1 << 3; tick[1] = 1'b1;
    @(negedge clk); sync = '0; tick = '0;
    capture(0); rd(2'd2, d);
    chk("R5 sync beats tick", {16'd0, d}, 32'd0);
    run_ticks(1, 2);
    sync_pulse(32'd1 << 5);
    capture(0); rd(2'd2, d);
    chk("R5 other line ignored", {16'd0, d}, 32'd2);
    wr(2'd0, mk(2'd1, 1'b0, 1'b0, 5'd0, 5'd1));
    sync_pulse(32'hFFFF_FFFF);
    run_ticks(1, 1);
    capture(0); rd(2'd2, d);
    chk("R5 select 0 free running", {16'd0, d}, 32'd3);

    // R6: triggered start
    wr(2'd0, mk(2'd1, 1'b1, 1'b0, 5'd4, 5'd1));
    run_ticks(1, 10);
    capture(0); rd(2'd2, d);
    chk("R6 held before trigger", {16'd0, d}, 32'd0);
    sync_pulse(32'd1 << 4);
    run_ticks(1, 7);
    capture(0); rd(2'd2, d);
    chk("R6 runs after trigger", {16'd0, d}, 32'd7);
    sync_pulse(32'd1 << 4);
    run_ticks(1, 3);
    capture(0); rd(2'd2, d);
    chk("R6 later trigger no clear", {16'd0, d}, 32'd10);

    // R10: independent channels
    wr(2'd0, mk(2'd1, 1'b0, 1'b0, 5'd3, 5'd1));
    wr(2'd1, mk(2'd1, 1'b0, 1'b0, 5'd6, 5'd7));
    sync_pulse((32'd1 << 3) | (32'd1 << 6));
    run_ticks(7, 9);
    run_ticks(1, 4);
    capture(1); rd(2'd3, d);
    chk("R10 ch1 own count", {16'd0, d}, 32'd9);
    chk("R10 ch1 irq", irq1_n, 32'd1);
    chk("R10 ch0 no irq", irq0_n, 32'd0);
    capture(0); rd(2'd2, d);
    chk("R10 ch0 own count", {16'd0, d}, 32'd4);

    // R7 / R8 / R9: cascade
    wr(2'd0, mk(2'd1, 1'b0, 1'b1, 5'd2, 5'd1));
    capture(1); rd(2'd3, d);
    chk("R7 ch1 pin ignored", {16'd0, d}, 32'd9);
    chk("R9 irq1 quiet", irq1_n, 32'd0);
    sync_pulse(32'd1 << 2);
    run_ticks(1, 65535);
    capture(0); rd(2'd2, d); rd(2'd3, d2);
    chk("R9 32-bit before carry", {d2, d}, 32'h0000_FFFF);
    chk("R9 irq0 pulse", irq0_n, 32'd1);
    chk("R9 irq1 silent", irq1_n, 32'd0);
    run_ticks(1, 2);
    capture(0); rd(2'd2, d); rd(2'd3, d2);
    chk("R7 carry into high half", {d2, d}, 32'h0001_0001);
    run_ticks(7, 5);
    sync_pulse(32'd1 << 6);
    capture(0); rd(2'd2, d); rd(2'd3, d2);
    chk("R7 ch1 selects ignored", {d2, d}, 32'h0001_0001);
    sync_pulse(32'd1 << 2);
    capture(0); rd(2'd2, d); rd(2'd3, d2);
    chk("R8 sync clears both halves", {d2, d}, 32'h0000_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule